// File: doc/BRIEF.md
# Multiplexed Bus ROM and I/O Read Front End

This block sits between an 8-bit processor bus, on which address and data share the same wires, and a combined ROM and I/O peripheral. While the address strobe is high it captures the low address byte, three upper address bits, the memory/I-O select and two chip enables, and it keeps them once the strobe drops. Reads then take either a byte from an internal 2048-word ROM or a byte supplied by a separate port block. A dedicated I/O-read input has the same effect as a memory read with the I/O select set.

The tristate bus is modelled as a data output plus an output enable. The wait line is modelled the same way. The block drives the wait line low while a selected strobe is in progress and lets it go on the following clock edge. The port block receives a two-bit target select and read and write strobes, and supplies its read value in return. Everything is synchronous to one clock, and the strobe is sampled on that clock.

Top module: `mbus_rom_if`

## Requirements
- R1: On every clock edge at which `ale` is high, the fields `ad_in`, `a_hi`, `io_m`, `ce_n` and `ce` are captured. On edges at which `ale` is low, the captured values stay unchanged whatever the inputs do.
- R2: The device is selected only if `ce_n` was 0 and `ce` was 1 at the last capture. After reset it is unselected until the first capture.
- R3: When selected, with captured `io_m`=0, `rd_n`=0 and `ior_n`=1 sampled at an edge, `bus_out` after that edge equals ROM word {a_hi,ad_in} as captured at least two edges earlier. Word i is the low 8 bits of (i*37) XOR (i>>3) XOR 0x5A.
- R4: When selected, with `ior_n`=0, or with captured `io_m`=1 and `rd_n`=0, `bus_out` after the edge equals `io_rdata` sampled at that edge. `ior_n`=0 takes precedence over a ROM read.
- R5: `bus_oe` is 1 after an edge only if the device was selected and `rd_n` or `ior_n` was 0 at that edge. Otherwise `bus_oe` is 0 and `bus_out` is 0.
- R6: `ready_oe` is 1, with `ready_out`=0, after each edge at which `ale`=1, `ce_n`=0 and `ce`=1. It returns to 0 after the first edge without that condition.
- R7: `io_sel` equals the two low bits of the captured `ad_in`. The upper address bits do not affect it.
- R8: `io_wr` is 1 after an edge at which the device was selected and `iow_n`=0, whatever the value of `io_m`. `io_rd` is 1 exactly when an I/O read (R4) drives the bus.
- R9: A synchronous reset leaves `bus_oe`, `bus_out`, `ready_oe`, `io_rd`, `io_wr` and `io_sel` at 0 and `ready_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address capture strobe |
| ad_in | input | 8 | Low address byte from the shared bus |
| a_hi | input | 3 | Upper address bits |
| io_m | input | 1 | 1 selects I/O space, 0 selects the ROM |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| rd_n | input | 1 | Active-low read |
| ior_n | input | 1 | Active-low dedicated I/O read |
| iow_n | input | 1 | Active-low I/O write |
| io_rdata | input | 8 | Read value from the port block |
| bus_out | output | 8 | Data driven onto the shared bus |
| bus_oe | output | 1 | Bus output enable |
| ready_out | output | 1 | Wait line level |
| ready_oe | output | 1 | Wait line output enable |
| io_sel | output | 2 | Captured I/O target select |
| io_rd | output | 1 | I/O read strobe to the port block |
| io_wr | output | 1 | I/O write strobe to the port block |

## Verification
The bench builds the block with its default parameters: an 8-bit low address, 3 upper bits, 8-bit data and ROM key 0x5A. This gives the full 2048-word space, so the reads at address 0 and at address 2047 exercise both ends of the captured address. Every output is compared with a behavioural model on every clock. The model covers reads driven on the bus while disabled, a read request with both read inputs active at once, strobes held for more than one cycle, and changes on the address wires after the capture.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_IO   = 2'd2
  } rd_src_e;

  function automatic logic [31:0] rom_word(input int unsigned idx, input int unsigned key);
    return (idx * 32'd37) ^ (idx >> 3) ^ key;
  endfunction

endpackage

// File: rtl/mbus_latch.sv
module mbus_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 3,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              io_m,
  input  logic              ce_n,
  input  logic              ce,
  output logic [ADDR_W-1:0] addr_q,
  output logic              iom_q,
  output logic              en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      iom_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (ale) begin
      addr_q <= {a_hi, ad_in};
      iom_q  <= io_m;
      en_q   <= ~ce_n & ce;
    end
  end

endmodule

// File: rtl/mbus_rom.sv
module mbus_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int unsigned KEY = 32'h5A,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data_q
);
  import mbus_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(rom_word(unsigned'(i), KEY));
    end
  end

  always_ff @(posedge clk) begin
    data_q <= mem[addr];
  end

endmodule

// File: rtl/mbus_ready.sv
module mbus_ready (
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  logic ce_n,
  input  logic ce,
  output logic ready_out,
  output logic ready_oe
);

  logic hold;
  assign hold = ale & ~ce_n & ce;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_oe  <= 1'b0;
      ready_out <= 1'b1;
    end else begin
      ready_oe  <= hold;
      ready_out <= ~hold;
    end
  end

endmodule

// File: rtl/mbus_rom_if.sv
module mbus_rom_if #(
  parameter int LO_W = 8,
  parameter int HI_W = 3,
  parameter int DATA_W = 8,
  parameter int unsigned ROM_KEY = 32'h5A,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              io_m,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              rd_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ready_out,
  output logic              ready_oe,
  output logic [1:0]        io_sel,
  output logic              io_rd,
  output logic              io_wr
);
  import mbus_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic              iom_q;
  logic              en_q;
  logic [DATA_W-1:0] rom_q;
  rd_src_e           src;

  mbus_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .io_m(io_m), .ce_n(ce_n), .ce(ce),
    .addr_q(addr_q), .iom_q(iom_q), .en_q(en_q)
  );

  mbus_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(ROM_KEY)) u_rom (
    .clk(clk), .addr(addr_q), .data_q(rom_q)
  );

  mbus_ready u_ready (
    .clk(clk), .rst(rst), .ale(ale), .ce_n(ce_n), .ce(ce),
    .ready_out(ready_out), .ready_oe(ready_oe)
  );

  always_comb begin
    src = SRC_NONE;
    if (en_q) begin
      if (!ior_n || (iom_q && !rd_n)) src = SRC_IO;
      else if (!rd_n)                 src = SRC_ROM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
      io_rd   <= 1'b0;
      io_wr   <= 1'b0;
    end else begin
      bus_oe <= (src != SRC_NONE);
      io_rd  <= (src == SRC_IO);
      io_wr  <= en_q & ~iow_n;
      unique case (src)
        SRC_IO:  bus_out <= io_rdata;
        SRC_ROM: bus_out <= rom_q;
        default: bus_out <= '0;
      endcase
    end
  end

  assign io_sel = addr_q[1:0];

endmodule

// File: rtl/mbus_rom_if_chk.sv
module mbus_rom_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       ale,
  input logic       ce_n,
  input logic       ce,
  input logic       rd_n,
  input logic       ior_n,
  input logic       iow_n,
  input logic       en_q,
  input logic       bus_oe,
  input logic       ready_out,
  input logic       ready_oe,
  input logic [1:0] io_sel,
  input logic       io_rd,
  input logic       io_wr
);

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !ior_n) == 1'b0 |=> !bus_oe) else $error("oe without read"); // R5

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !bus_oe) else $error("oe while unselected"); // R2

  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (ale && !ce_n && ce) |=> (ready_oe && !ready_out)) else $error("ready not pulled"); // R6

  AST_READY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !(ale && !ce_n && ce) |=> !ready_oe) else $error("ready held"); // R6

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(io_sel)) else $error("io_sel moved"); // R1

  AST_IORD_DRIVES: assert property (@(posedge clk) disable iff (rst)
    io_rd |-> bus_oe) else $error("io_rd without oe"); // R8

  AST_IOWR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    iow_n |=> !io_wr) else $error("io_wr without write"); // R8

endmodule

bind mbus_rom_if mbus_rom_if_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .ce_n(ce_n), .ce(ce), .rd_n(rd_n),
  .ior_n(ior_n), .iow_n(iow_n), .en_q(en_q), .bus_oe(bus_oe),
  .ready_out(ready_out), .ready_oe(ready_oe), .io_sel(io_sel),
  .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/mbus_rom_if_bench.sv
module mbus_rom_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0;
  logic [7:0] ad_in = 8'h00;
  logic [2:0] a_hi = 3'd0;
  logic io_m = 1'b0, ce_n = 1'b1, ce = 1'b0;
  logic rd_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [7:0] io_rdata = 8'h00;
  logic [7:0] bus_out;
  logic bus_oe, ready_out, ready_oe, io_rd, io_wr;
  logic [1:0] io_sel;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference state
  bit m_en = 0, m_iom = 0;
  int unsigned m_addr = 0;
  logic [7:0] m_romq = 8'h00;
  logic [7:0] e_out = 0;
  bit e_oe = 0, e_rdy_oe = 0, e_rdy_out = 1, e_iord = 0, e_iowr = 0, e_rom = 0;
  logic [1:0] e_sel = 0;

  mbus_rom_if u_mbus_rom_if (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi), .io_m(io_m),
    .ce_n(ce_n), .ce(ce), .rd_n(rd_n), .ior_n(ior_n), .iow_n(iow_n),
    .io_rdata(io_rdata), .bus_out(bus_out), .bus_oe(bus_oe),
    .ready_out(ready_out), .ready_oe(ready_oe), .io_sel(io_sel),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_ref(input int unsigned i);
    int unsigned v;
    v = (i * 37) ^ (i >> 3) ^ 32'h5A;
    return v[7:0];
  endfunction

  always @(posedge clk) begin
    bit rd_any, io_path;
    cyc++;
    if (rst) begin
      m_en = 0; m_iom = 0; m_addr = 0;
      e_out = 0; e_oe = 0; e_rdy_oe = 0; e_rdy_out = 1; e_iord = 0; e_iowr = 0;
      e_sel = 0; e_rom = 0;
    end else begin
      rd_any  = !rd_n || !ior_n;
      io_path = !ior_n || (m_iom && !rd_n);
      e_oe    = m_en && rd_any;
      e_iord  = e_oe && io_path;
      e_rom   = e_oe && !io_path;
      e_out   = !e_oe ? 8'h00 : (io_path ? io_rdata : m_romq);
      e_iowr  = m_en && !iow_n;
      e_rdy_oe  = ale && !ce_n && ce;
      e_rdy_out = !e_rdy_oe;
      if (ale) begin
        m_addr = {a_hi, ad_in};
        m_iom  = io_m;
        m_en   = !ce_n && ce;
      end
      e_sel = m_addr[1:0];
    end
    m_romq = rom_ref(m_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_oe == e_oe, "R2 R5 bus_oe", 32'(bus_oe), 32'(e_oe));
      chk(bus_out == e_out, e_rom ? "R3 rom data" : "R4 io data", 32'(bus_out), 32'(e_out));
      chk(ready_oe == e_rdy_oe, "R6 ready_oe", 32'(ready_oe), 32'(e_rdy_oe));
      if (ready_oe) chk(ready_out == e_rdy_out, "R6 ready level", 32'(ready_out), 32'(e_rdy_out));
      chk(io_sel == e_sel, "R1 R7 io_sel", 32'(io_sel), 32'(e_sel));
      chk(io_rd == e_iord, "R8 io_rd", 32'(io_rd), 32'(e_iord));
      chk(io_wr == e_iowr, "R8 io_wr", 32'(io_wr), 32'(e_iowr));
    end
  end

  always @(posedge clk) begin
    if (cyc == WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input int unsigned addr, input bit iom, input bit en_l,
                         input bit en_h, input int hold);
    ale = 1; ad_in = addr[7:0]; a_hi = addr[10:8]; io_m = iom; ce_n = en_l; ce = en_h;
    step(hold);
    ale = 0; ad_in = ~ad_in; a_hi = ~a_hi; io_m = ~io_m; ce_n = ~ce_n; ce = ~ce;
    step(2);
  endtask

  task automatic rd_cycle(input bit use_rd, input bit use_ior, input logic [7:0] pv);
    io_rdata = pv; rd_n = !use_rd; ior_n = !use_ior;
    step(2);
    rd_n = 1; ior_n = 1;
    step(1);
  endtask

  task automatic wr_cycle();
    iow_n = 0; step(1); iow_n = 1; step(1);
  endtask

  initial begin
    step(3);
    rst = 0;
    @(posedge clk); #1;
    // R9 reset state, sampled after first edge out of reset
    chk(bus_oe == 0 && bus_out == 0, "R9 bus idle", {bus_oe, bus_out}, 0);
    chk(ready_oe == 0 && ready_out == 1, "R9 ready idle", {ready_oe, ready_out}, 1);
    chk(io_rd == 0 && io_wr == 0 && io_sel == 0, "R9 strobes", {io_rd, io_wr, io_sel}, 0);
    step(1);
    // R2: unselected before any capture
    rd_cycle(1, 0, 8'h11);
    rd_cycle(0, 1, 8'h22);
    wr_cycle();
    // R3 ROM reads at ends and middle
    capture(0, 0, 0, 1, 1);
    rd_cycle(1, 0, 8'h33);
    capture(2047, 0, 0, 1, 2);
    rd_cycle(1, 0, 8'h44);
    capture(11'h2C5, 0, 0, 1, 1);
    rd_cycle(1, 0, 8'h55);
    // R4 io reads, both forms, and precedence
    capture(11'h702, 1, 0, 1, 1);
    rd_cycle(1, 0, 8'hA5);
    capture(11'h403, 0, 0, 1, 1);
    rd_cycle(0, 1, 8'h5A);
    rd_cycle(1, 1, 8'hC3);
    // R8 write ignoring io_m
    wr_cycle();
    capture(11'h101, 1, 0, 1, 1);
    wr_cycle();
    // R2 disabled by either enable
    capture(11'h123, 0, 1, 1, 1);
    rd_cycle(1, 0, 8'h77);
    wr_cycle();
    capture(11'h124, 0, 0, 0, 2);
    rd_cycle(0, 1, 8'h66);
    capture(11'h0FE, 0, 1, 0, 1);
    rd_cycle(1, 1, 8'h99);
    // reset in the middle clears selection
    capture(11'h555, 0, 0, 1, 1);
    rst = 1; step(2); rst = 0; step(1);
    rd_cycle(1, 0, 8'h12);
    capture(11'h3FF, 0, 0, 1, 3);
    rd_cycle(1, 0, 8'h34);
    step(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule